// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Line Status

This block sits between the bit-level receiver of a UART and the host. Each character that the receiver completes is written into a first-in, first-out queue along with its own tags: the ninth bit, and flags for noise, a line break, a framing error and a parity error. A break arrives as an all-zero character whose break tag marks it apart from an ordinary zero byte. When the queue is full, any new character is thrown away, the queued ones are kept, and an overrun flag is raised.

When the host pulses its read strobe, the oldest character moves into a holding register, and its tags are loaded into an eight-bit line status byte. The status therefore always describes the character most recently read. The error bits are sticky. They collect over erroneous characters and clear only when a character with no errors is read, so reading the status byte never clears it. The status byte also carries the live clear-to-send level and a receive-timeout flag that is driven from outside. A single interrupt output combines the status error bits with an enable mask. A mode input selects between parity checking and nine-bit multidrop operation. In multidrop operation, status bit 2 shows the ninth bit of the character that was read.

Top module: `uart_rx_status_queue`

## Requirements
- R1: After reset `host_data` is 0, `line_status` bits 5..1 are 0, and `line_irq` is 0 while all five enables are set.
- R2: Characters leave in the order they were accepted. The popped data appears on `host_data` one cycle after a `host_rd` pulse and is held until the next `host_rd`.
- R3: A write with `rx_break` set is stored with data 0 and a break tag. Reading it sets `line_status[4]`.
- R4: A popped character is erroneous if its noise, break or framing tag is set, or, in parity mode, its parity tag. Reading an erroneous character ORs its tags into `line_status[5]` (noise), `[4]` (break) and `[3]` (framing). Reading a character with none of these errors clears all three bits, so the break bit clears after the clean character that follows a break.
- R5: A write while the queue holds DEPTH characters is dropped, even if a pop happens in the same cycle, and the queued data is unchanged. The write sets `line_status[1]`. This bit stays set until a clean character is read or reset is applied. When both happen in one cycle, the set wins.
- R6: With `multidrop_en` = 1, the parity tag is not an error, and `line_status[2]` takes the ninth bit of the character just read.
- R7: With `multidrop_en` = 0, `line_status[2]` is the sticky parity-error bit under the rule of R4.
- R8: `line_status[7]` follows `cts_level` and `line_status[0]` follows `timeout_pending` in the same cycle. `line_status[6]` is always 0.
- R9: `line_irq` is the OR of `line_status[i+1] & irq_en[i]` for i = 0..4. It reacts to mask changes in the same cycle.
- R10: A `host_rd` while the queue is empty loads 0 into `host_data` and leaves `line_status` bits 5..1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receiver presents a character this cycle |
| rx_data | input | DATA_W | Received character |
| rx_bit9 | input | 1 | Ninth (address/data) bit |
| rx_noise | input | 1 | Noise seen during the character |
| rx_break | input | 1 | Line break detected |
| rx_frame_err | input | 1 | Stop-bit framing error |
| rx_parity_err | input | 1 | Parity mismatch |
| multidrop_en | input | 1 | 1: nine-bit multidrop mode, 0: parity mode |
| timeout_pending | input | 1 | External receive-timeout flag |
| host_rd | input | 1 | Host read strobe, one pulse per character |
| irq_en | input | 5 | Interrupt enables for status bits 5..1 (bit i enables bit i+1) |
| cts_level | input | 1 | Live clear-to-send input |
| host_data | output | DATA_W | Holding register |
| line_status | output | 8 | Status of the last character read |
| line_irq | output | 1 | Combined line-status interrupt |

## Verification
The bench builds the block with DEPTH = 16 and DATA_W = 8. The small depth lets the queue be filled, overrun by several writes and fully drained within a few dozen cycles, so the full-queue drop and the rule that the overrun set wins over the clear are both reached. A behavioural queue model is compared with the outputs on every cycle. The bench switches between parity and multidrop mode on the same tag patterns, and it sweeps all 32 enable masks over a fixed set of status bits.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Status byte bit positions (host-visible layout)
  localparam int ST_CTS     = 7;
  localparam int ST_ZERO    = 6;
  localparam int ST_NOISE   = 5;
  localparam int ST_BREAK   = 4;
  localparam int ST_FRAME   = 3;
  localparam int ST_PAR_B9  = 2;
  localparam int ST_OVERRUN = 1;
  localparam int ST_TIMEOUT = 0;
  localparam int IRQ_SRC_N  = 5;

  typedef struct packed {
    logic bit9;
    logic noise;
    logic brk;
    logic frame;
    logic parity;
  } rx_tags_t;

  // A character counts as erroneous when any checked tag is set.
  function automatic logic tags_error(rx_tags_t t, logic multidrop);
    return t.noise | t.brk | t.frame | (t.parity & ~multidrop);
  endfunction

  // Combined interrupt from status bits 5..1 and their enables.
  function automatic logic irq_combine(logic [7:0] st, logic [IRQ_SRC_N-1:0] en);
    return |(st[ST_NOISE:ST_OVERRUN] & en);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  rx_tags_t          push_tags,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output rx_tags_t          head_tags,
  output logic              empty,
  output logic              full,
  output logic              pop_fire,
  output logic              drop_evt
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] data_mem [DEPTH];
  rx_tags_t          tag_mem  [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill;
  logic              push_fire;

  function automatic logic [PW-1:0] ptr_step(logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (fill == '0);
  assign full      = (fill == FULL_CNT);
  assign push_fire = push_req & ~full;
  assign pop_fire  = pop_req & ~empty;
  assign drop_evt  = push_req & full;
  assign head_data = data_mem[rd_ptr];
  assign head_tags = tag_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) begin
      data_mem[wr_ptr] <= push_data;
      tag_mem[wr_ptr]  <= push_tags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_fire) wr_ptr <= ptr_step(wr_ptr);
      if (pop_fire)  rd_ptr <= ptr_step(rd_ptr);
      case ({push_fire, pop_fire})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_CNT);

  assert_drop_keeps_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt && !pop_fire |=> fill == $past(fill));

  assert_empty_read_no_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && empty && !push_req |=> empty && rd_ptr == $past(rd_ptr));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_strobe,
  input  logic                 pop_fire,
  input  logic [DATA_W-1:0]    head_data,
  input  rx_tags_t             head_tags,
  input  logic                 multidrop,
  input  logic                 drop_evt,
  input  logic                 cts,
  input  logic                 timeout,
  input  logic [IRQ_SRC_N-1:0] irq_en,
  output logic [DATA_W-1:0]    rd_data,
  output logic [7:0]           status,
  output logic                 irq
);

  logic err_noise_q, err_brk_q, err_frame_q, bit2_q, ovr_q;
  logic err_noise_d, err_brk_d, err_frame_d, bit2_d, ovr_d;
  logic hit_err, clean_pop;
  logic [DATA_W-1:0] rd_data_d;

  assign hit_err   = tags_error(head_tags, multidrop);
  assign clean_pop = pop_fire & ~hit_err;

  always_comb begin
    err_noise_d = err_noise_q;
    err_brk_d   = err_brk_q;
    err_frame_d = err_frame_q;
    bit2_d      = bit2_q;
    if (pop_fire) begin
      if (hit_err) begin
        err_noise_d = err_noise_q | head_tags.noise;
        err_brk_d   = err_brk_q   | head_tags.brk;
        err_frame_d = err_frame_q | head_tags.frame;
        bit2_d      = multidrop ? head_tags.bit9 : (bit2_q | head_tags.parity);
      end else begin
        err_noise_d = 1'b0;
        err_brk_d   = 1'b0;
        err_frame_d = 1'b0;
        bit2_d      = multidrop ? head_tags.bit9 : 1'b0;
      end
    end
    ovr_d = ovr_q;
    if (clean_pop) ovr_d = 1'b0;
    if (drop_evt)  ovr_d = 1'b1;
  end

  always_comb begin
    rd_data_d = rd_data;
    if (rd_strobe) rd_data_d = pop_fire ? head_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_noise_q <= 1'b0;
      err_brk_q   <= 1'b0;
      err_frame_q <= 1'b0;
      bit2_q      <= 1'b0;
      ovr_q       <= 1'b0;
      rd_data     <= '0;
    end else begin
      err_noise_q <= err_noise_d;
      err_brk_q   <= err_brk_d;
      err_frame_q <= err_frame_d;
      bit2_q      <= bit2_d;
      ovr_q       <= ovr_d;
      rd_data     <= rd_data_d;
    end
  end

  always_comb begin
    status             = '0;
    status[ST_CTS]     = cts;
    status[ST_ZERO]    = 1'b0;
    status[ST_NOISE]   = err_noise_q;
    status[ST_BREAK]   = err_brk_q;
    status[ST_FRAME]   = err_frame_q;
    status[ST_PAR_B9]  = bit2_q;
    status[ST_OVERRUN] = ovr_q;
    status[ST_TIMEOUT] = timeout;
  end

  assign irq = irq_combine(status, irq_en);

  assert_break_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && head_tags.brk |=> rd_data == '0 && status[ST_BREAK]);

  assert_clean_pop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clean_pop && !multidrop && !drop_evt |=> status[ST_NOISE:ST_OVERRUN] == '0);

  assert_sticky_errors_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && hit_err |=>
      (status[ST_NOISE:ST_FRAME] & $past(status[ST_NOISE:ST_FRAME])) == $past(status[ST_NOISE:ST_FRAME]));

  assert_drop_flags_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> status[ST_OVERRUN]);

  assert_multidrop_bit9_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && multidrop |=> status[ST_PAR_B9] == $past(head_tags.bit9));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !pop_fire && !drop_evt |=> rd_data == '0 && $stable(status[ST_NOISE:ST_OVERRUN]));

endmodule

// File: rtl/uart_rx_status_queue.sv
module uart_rx_status_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bit9,
  input  logic              rx_noise,
  input  logic              rx_break,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              multidrop_en,
  input  logic              timeout_pending,
  input  logic              host_rd,
  input  logic [4:0]        irq_en,
  input  logic              cts_level,
  output logic [DATA_W-1:0] host_data,
  output logic [7:0]        line_status,
  output logic              line_irq
);

  rx_tags_t          wr_tags, head_tags;
  logic [DATA_W-1:0] wr_data, head_data;
  logic              q_empty, q_full, pop_fire, drop_evt;

  // A break is queued as an all-zero character carrying its break tag.
  assign wr_data        = rx_break ? '0 : rx_data;
  assign wr_tags.bit9   = rx_bit9;
  assign wr_tags.noise  = rx_noise;
  assign wr_tags.brk    = rx_break;
  assign wr_tags.frame  = rx_frame_err;
  assign wr_tags.parity = rx_parity_err;

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (rx_valid),
    .push_data (wr_data),
    .push_tags (wr_tags),
    .pop_req   (host_rd),
    .head_data (head_data),
    .head_tags (head_tags),
    .empty     (q_empty),
    .full      (q_full),
    .pop_fire  (pop_fire),
    .drop_evt  (drop_evt)
  );

  rxq_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (host_rd),
    .pop_fire  (pop_fire),
    .head_data (head_data),
    .head_tags (head_tags),
    .multidrop (multidrop_en),
    .drop_evt  (drop_evt),
    .cts       (cts_level),
    .timeout   (timeout_pending),
    .irq_en    (irq_en),
    .rd_data   (host_data),
    .status    (line_status),
    .irq       (line_irq)
  );

  assert_full_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

endmodule

// File: tb/sim_uart_rx_status_queue.sv
module sim_uart_rx_status_queue;

  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_bit9 = 0, rx_noise = 0, rx_break = 0, rx_frame_err = 0, rx_parity_err = 0;
  logic [DATA_W-1:0] rx_data = '0;
  logic multidrop_en = 0, timeout_pending = 0, host_rd = 0, cts_level = 1;
  logic [4:0] irq_en = 5'b11111;
  logic [DATA_W-1:0] host_data;
  logic [7:0] line_status;
  logic line_irq;

  always #10 clk = ~clk;  // 50 MHz

  uart_rx_status_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_noise(rx_noise), .rx_break(rx_break), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .multidrop_en(multidrop_en),
    .timeout_pending(timeout_pending), .host_rd(host_rd), .irq_en(irq_en),
    .cts_level(cts_level), .host_data(host_data), .line_status(line_status),
    .line_irq(line_irq)
  );

  // Reference model: entries packed as int {par[12], frame[11], brk[10], noise[9], bit9[8], data[7:0]}
  int q[$];
  int m_data;
  bit m_noise, m_brk, m_frame, m_b2, m_ovr;
  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_data = 0; m_noise = 0; m_brk = 0; m_frame = 0; m_b2 = 0; m_ovr = 0;
    end else begin
      bit was_full, clean;
      was_full = (q.size() == DEPTH);
      clean = 0;
      if (host_rd) begin
        if (q.size() > 0) begin
          int e;
          bit en, eb, ef, ep, err;
          e = q[0];
          q.delete(0);
          en = e[9]; eb = e[10]; ef = e[11];
          ep = multidrop_en ? 1'b0 : e[12];
          err = en | eb | ef | ep;
          m_data = e & 8'hFF;
          if (err) begin
            m_noise |= en; m_brk |= eb; m_frame |= ef;
            m_b2 = multidrop_en ? e[8] : (m_b2 | ep);
          end else begin
            m_noise = 0; m_brk = 0; m_frame = 0;
            m_b2 = multidrop_en ? e[8] : 1'b0;
            clean = 1;
          end
        end else begin
          m_data = 0;  // R10 empty read returns zero
        end
      end
      if (clean) m_ovr = 0;
      if (rx_valid) begin
        if (was_full) m_ovr = 1;  // R5 drop, set wins
        else begin
          int d;
          d = rx_break ? 0 : int'(rx_data);
          q.push_back(d | (int'(rx_bit9) << 8) | (int'(rx_noise) << 9) | (int'(rx_break) << 10)
                        | (int'(rx_frame_err) << 11) | (int'(rx_parity_err) << 12));
        end
      end
    end
  end

  function automatic string bit_tag(int i);
    case (i)
      7, 6, 0: return "R8";
      5, 3:    return "R4";
      4:       return "R3";
      2:       return "R6/R7";
      default: return "R5";
    endcase
  endfunction

  // Compare every cycle on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_st;
      logic exp_irq;
      exp_st = {cts_level, 1'b0, m_noise, m_brk, m_frame, m_b2, m_ovr, timeout_pending};
      exp_irq = |(exp_st[5:1] & irq_en);
      vectors++;
      if (host_data !== m_data[DATA_W-1:0]) begin
        fails++;
        $display("FAIL R2 host_data actual=%h expected=%h", host_data, m_data[DATA_W-1:0]);
      end
      for (int i = 0; i < 8; i++) begin
        if (line_status[i] !== exp_st[i]) begin
          fails++;
          $display("FAIL %s line_status[%0d] actual=%b expected=%b", bit_tag(i), i, line_status[i], exp_st[i]);
        end
      end
      if (line_irq !== exp_irq) begin
        fails++;
        $display("FAIL R9 line_irq actual=%b expected=%b mask=%b", line_irq, exp_irq, irq_en);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d cycles expected<20000", cycles);
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic push(input logic [7:0] d, input bit b9, input bit n, input bit br, input bit f, input bit p);
    rx_valid = 1; rx_data = d; rx_bit9 = b9; rx_noise = n; rx_break = br; rx_frame_err = f; rx_parity_err = p;
    step();
    rx_valid = 0; rx_bit9 = 0; rx_noise = 0; rx_break = 0; rx_frame_err = 0; rx_parity_err = 0;
  endtask

  task automatic pop();
    host_rd = 1;
    step();
    host_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();
    // R1: reset state, covered by the per-cycle compare
    if (host_data !== '0 || line_status[5:1] !== 5'b0 || line_irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset actual=%h/%b expected=00/00000", host_data, line_status[5:1]);
    end
    vectors++;
    // R2 ordering
    push(8'h41, 0, 0, 0, 0, 0); push(8'h42, 0, 0, 0, 0, 0);
    pop(); pop(); step();
    // R10 read of an empty queue
    pop(); step();
    // R3/R4 break then a plain zero and a normal character
    push(8'h55, 0, 0, 1, 0, 0); push(8'h00, 0, 0, 0, 0, 0); push(8'h33, 0, 0, 0, 0, 0);
    pop(); step(); pop(); step(); pop();
    // R4 sticky accumulation
    push(8'h10, 0, 0, 0, 1, 0); push(8'h11, 0, 1, 0, 0, 0); push(8'h12, 0, 0, 0, 0, 0);
    pop(); pop(); step(); pop(); step();
    // R7 parity mode
    push(8'h20, 1, 0, 0, 0, 1); push(8'h21, 1, 0, 0, 0, 0);
    pop(); step(); pop();
    // R6 multidrop mode on the same tag patterns
    multidrop_en = 1;
    push(8'h30, 1, 0, 0, 0, 1); push(8'h31, 0, 0, 0, 0, 1); push(8'h32, 1, 1, 0, 0, 0);
    pop(); pop(); pop(); step();
    multidrop_en = 0;
    push(8'h01, 0, 0, 0, 0, 0); pop();
    // R5 fill past depth, then drain
    for (int i = 0; i < DEPTH + 3; i++) push(8'(8'h80 + i), 0, 0, 0, 0, 0);
    // push while full with a simultaneous pop: dropped, set wins over clear
    host_rd = 1; rx_valid = 1; rx_data = 8'hEE; step(); host_rd = 0; rx_valid = 0;
    for (int i = 0; i < DEPTH + 1; i++) pop();
    step();
    // R9 mask sweep over a fixed set of status bits
    push(8'h40, 0, 1, 0, 1, 1); pop();
    for (int m = 0; m < 32; m++) begin
      irq_en = 5'(m); step();
    end
    irq_en = 5'b11111;
    // R8 live inputs
    cts_level = 0; step(); timeout_pending = 1; step(); cts_level = 1; step(); timeout_pending = 0; step();
    // simultaneous push and pop with one character queued
    push(8'h60, 0, 0, 0, 0, 0);
    host_rd = 1; rx_valid = 1; rx_data = 8'h61; step(); host_rd = 0; rx_valid = 0;
    pop(); step(); step();
    finish_run();
  end

endmodule